// File: doc/BRIEF.md
# Lockable identification page controller

This block holds a 32-byte side page that sits beside the main memory array of a two-wire serial memory. The shared serial engine turns bus activity into single-cycle events: a start condition, a stop condition, or one complete byte from the host. The block watches the control byte that follows each start. It responds to the side-page type code and ignores everything else, which stays with the main array logic.

A write session carries two address bytes. One bit of the high address byte chooses between two forms:

- **Page data write.** Bytes are staged and then committed at stop.
- **Lock command.** The session permanently freezes the page when its data byte has bit 1 set.

For every byte it receives, the block tells the engine whether to acknowledge. A locked page refuses data bytes. Because of that refusal, a one-byte write followed by a fresh start works as a harmless probe of the lock state.

Reads use the usual random-read form: a dummy write sets the byte pointer, then a restart is followed by a read control byte. The selected byte is presented to the engine. Each advance moves the pointer to the next byte, wrapping inside the page.

Top module: `idp_page_ctrl`

## Requirements
- R1: A control byte whose bits [7:4] are 4'b1011 and whose bits [3:1] equal `pins_i` is acknowledged. Any other control byte is refused, and every later byte up to the next start is refused and has no effect.
- R2: In a write session (control bit 0 = 0), both address bytes are acknowledged. Bit 2 of the first address byte is the form select, where 0 means page data write and 1 means lock command. Bits [4:0] of the second address byte set the byte pointer. All other address bits are ignored.
- R3: In the page data write form, each data byte on an unlocked page is acknowledged and staged at the pointer, and the pointer then advances modulo 32. Staged bytes reach the page only at the stop, and a later byte sent to the same offset replaces the earlier one.
- R4: A start that arrives before the stop discards all staged bytes and any pending lock request, so the page and the lock stay as they were.
- R5: In the lock command form, the first data byte is acknowledged when the page is unlocked. If its bit 1 is 1, the page becomes locked at the stop. If its bit 1 is 0, the lock is unchanged. Any further data bytes in that session are refused.
- R6: While the page is locked, data bytes of either write form are refused and the page contents never change. An unlocked page acknowledges the probe byte and a locked page refuses it.
- R7: A read control byte (bit 0 = 1) that passes R1 is acknowledged and sets `rd_mode_o`. `rd_data_o` shows the page byte at the pointer, and each `rd_adv_i` pulse moves the pointer on by one modulo 32.
- R8: The lock is sticky. It is set by `lock_preload_i` or by a committed lock command, and only `rst_n` clears it. After reset the page is all zero, the pointer is 0, and the block is idle and unlocked.
- R9: `ack_vld_o` is high for exactly the cycle after each byte event, and `ack_o` carries the acknowledge decision for that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 3 | Strapped chip-select value compared with control bits [3:1] |
| ev_start_i | input | 1 | One-cycle pulse: start or repeated start seen |
| ev_stop_i | input | 1 | One-cycle pulse: stop seen |
| ev_byte_i | input | 1 | One-cycle pulse: a host byte is complete in `byte_i` |
| byte_i | input | 8 | Byte received from the host |
| rd_adv_i | input | 1 | One-cycle pulse: the read byte has been sent, so advance |
| lock_preload_i | input | 1 | Test preload that sets the lock |
| ack_o | output | 1 | Acknowledge decision for the last byte |
| ack_vld_o | output | 1 | `ack_o` is valid this cycle |
| rd_mode_o | output | 1 | A side-page read session is active |
| rd_data_o | output | 8 | Page byte at the current pointer |
| locked_o | output | 1 | Lock state |

## Verification
The acknowledge decision is registered, so it is due in the single cycle after a byte event. The bench drives each event on a falling edge and samples `ack_o` and `ack_vld_o` on the next falling edge. Staged bytes and a lock request both commit on the edge that samples the stop, so the bench reads them back only in a later read session. `rd_data_o` follows the pointer combinationally: it is compared on the falling edge after the read control byte and after each advance pulse.

// File: rtl/idp_pkg.sv
package idp_pkg;
  localparam logic [3:0] IDP_TYPE = 4'b1011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_LDAT,
    ST_LEND,
    ST_RD
  } idp_st_e;
endpackage

// File: rtl/idp_lock_reg.sv
module idp_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd_i,
  input  logic preload_i,
  output logic locked_o
);
  logic locked_q, locked_d;

  always_comb locked_d = locked_q | set_cmd_i | preload_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= locked_d;
  end

  assign locked_o = locked_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
endmodule

// File: rtl/idp_page_store.sv
module idp_page_store #(
  parameter int PAGE_BYTES = 32,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int PW = PAGE_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [OFS_W-1:0] wofs_i,
  input  logic [7:0]       wdata_i,
  input  logic             commit_i,
  input  logic             abort_i,
  input  logic             locked_i,
  input  logic [OFS_W-1:0] rofs_i,
  output logic [7:0]       rdata_o
);
  logic [PW-1:0]         page_q, page_d;
  logic [PW-1:0]         stage_q, stage_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;

  always_comb begin
    page_d  = page_q;
    stage_d = stage_q;
    mask_d  = mask_q;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (we_i && (wofs_i == i[OFS_W-1:0])) begin
        stage_d[i*8 +: 8] = wdata_i;
        mask_d[i]         = 1'b1;
      end
      if (commit_i && mask_q[i] && !locked_i)
        page_d[i*8 +: 8] = stage_q[i*8 +: 8];
      if (commit_i || abort_i)
        mask_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      stage_q <= '0;
      mask_q  <= '0;
    end else begin
      page_q  <= page_d;
      stage_q <= stage_d;
      mask_q  <= mask_d;
    end
  end

  assign rdata_o = page_q[{rofs_i, 3'b000} +: 8];

  // R6
  locked_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_i |=> $stable(page_q));

  // R4
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (mask_q == '0));
endmodule

// File: rtl/idp_cmd_fsm.sv
module idp_cmd_fsm
  import idp_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int SEL_BIT = 10,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int SEL_IN_HI = SEL_BIT - 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       pins_i,
  input  logic             ev_start_i,
  input  logic             ev_stop_i,
  input  logic             ev_byte_i,
  input  logic [7:0]       byte_i,
  input  logic             rd_adv_i,
  input  logic             locked_i,
  output logic             ack_o,
  output logic             ack_vld_o,
  output logic             rd_mode_o,
  output logic             stage_we_o,
  output logic             commit_o,
  output logic             abort_o,
  output logic             lock_set_o,
  output logic [OFS_W-1:0] ptr_o
);
  idp_st_e          st_q, st_d;
  logic [OFS_W-1:0] ptr_q, ptr_d;
  logic             sel_q, sel_d;
  logic             lpend_q, lpend_d;
  logic             ack_q, ack_d;
  logic             vld_q, vld_d;

  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    sel_d      = sel_q;
    lpend_d    = lpend_q;
    ack_d      = 1'b0;
    vld_d      = 1'b0;
    stage_we_o = 1'b0;
    commit_o   = 1'b0;
    abort_o    = 1'b0;
    lock_set_o = 1'b0;
    if (ev_start_i) begin
      st_d    = ST_CTRL;
      abort_o = 1'b1;
      lpend_d = 1'b0;
    end else if (ev_stop_i) begin
      commit_o   = (st_q == ST_WDAT);
      lock_set_o = lpend_q;
      abort_o    = (st_q != ST_WDAT);
      lpend_d    = 1'b0;
      st_d       = ST_IDLE;
    end else if (ev_byte_i) begin
      vld_d = 1'b1;
      unique case (st_q)
        ST_CTRL: begin
          if (byte_i[7:4] == IDP_TYPE && byte_i[3:1] == pins_i) begin
            ack_d = 1'b1;
            st_d  = byte_i[0] ? ST_RD : ST_AHI;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_AHI: begin
          ack_d = 1'b1;
          sel_d = byte_i[SEL_IN_HI];
          st_d  = ST_ALO;
        end
        ST_ALO: begin
          ack_d = 1'b1;
          ptr_d = byte_i[OFS_W-1:0];
          st_d  = sel_q ? ST_LDAT : ST_WDAT;
        end
        ST_WDAT: begin
          if (!locked_i) begin
            ack_d      = 1'b1;
            stage_we_o = 1'b1;
            ptr_d      = ptr_q + 1'b1;
          end
        end
        ST_LDAT: begin
          if (!locked_i) begin
            ack_d   = 1'b1;
            lpend_d = byte_i[1];
          end
          st_d = ST_LEND;
        end
        default: ack_d = 1'b0;
      endcase
    end else if (rd_adv_i && st_q == ST_RD) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      sel_q   <= 1'b0;
      lpend_q <= 1'b0;
      ack_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      sel_q   <= sel_d;
      lpend_q <= lpend_d;
      ack_q   <= ack_d;
      vld_q   <= vld_d;
    end
  end

  assign ack_o     = ack_q;
  assign ack_vld_o = vld_q;
  assign rd_mode_o = (st_q == ST_RD);
  assign ptr_o     = ptr_q;

  // R9
  byte_ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte_i && !ev_start_i && !ev_stop_i) |=> ack_vld_o);

  // R6
  locked_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte_i && !ev_start_i && !ev_stop_i && locked_i &&
     (st_q == ST_WDAT || st_q == ST_LDAT)) |=> !ack_o);

  // R1
  foreign_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && ev_byte_i && !ev_start_i && !ev_stop_i) |=> (!ack_o && st_q == ST_IDLE));

  // R5
  lock_end_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEND && ev_byte_i && !ev_start_i && !ev_stop_i) |=> !ack_o);
endmodule

// File: rtl/idp_page_ctrl.sv
module idp_page_ctrl #(
  parameter int PAGE_BYTES = 32,
  parameter int SEL_BIT = 10,
  localparam int OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pins_i,
  input  logic       ev_start_i,
  input  logic       ev_stop_i,
  input  logic       ev_byte_i,
  input  logic [7:0] byte_i,
  input  logic       rd_adv_i,
  input  logic       lock_preload_i,
  output logic       ack_o,
  output logic       ack_vld_o,
  output logic       rd_mode_o,
  output logic [7:0] rd_data_o,
  output logic       locked_o
);
  logic             locked;
  logic             stage_we, commit, abort, lock_set;
  logic [OFS_W-1:0] ptr;

  idp_cmd_fsm #(.PAGE_BYTES(PAGE_BYTES), .SEL_BIT(SEL_BIT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     (pins_i),
    .ev_start_i (ev_start_i),
    .ev_stop_i  (ev_stop_i),
    .ev_byte_i  (ev_byte_i),
    .byte_i     (byte_i),
    .rd_adv_i   (rd_adv_i),
    .locked_i   (locked),
    .ack_o      (ack_o),
    .ack_vld_o  (ack_vld_o),
    .rd_mode_o  (rd_mode_o),
    .stage_we_o (stage_we),
    .commit_o   (commit),
    .abort_o    (abort),
    .lock_set_o (lock_set),
    .ptr_o      (ptr)
  );

  idp_page_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (stage_we),
    .wofs_i   (ptr),
    .wdata_i  (byte_i),
    .commit_i (commit),
    .abort_i  (abort),
    .locked_i (locked),
    .rofs_i   (ptr),
    .rdata_o  (rd_data_o)
  );

  idp_lock_reg u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_cmd_i (lock_set),
    .preload_i (lock_preload_i),
    .locked_o  (locked)
  );

  assign locked_o = locked;
endmodule

// File: tb/test_idp_page_ctrl.sv
module test_idp_page_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pins_i = 3'b101;
  logic       ev_start_i = 1'b0, ev_stop_i = 1'b0, ev_byte_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       rd_adv_i = 1'b0, lock_preload_i = 1'b0;
  logic       ack_o, ack_vld_o, rd_mode_o, locked_o;
  logic [7:0] rd_data_o;

  int nvec = 0, nerr = 0;
  bit done = 1'b0;
  logic [7:0] ref_pg [32];
  bit ref_lock;

  always #10 clk = ~clk;

  idp_page_ctrl i_idp_page_ctrl (.*);

  function automatic bit exp_data_ack(bit lk);
    return !lk;
  endfunction

  function automatic logic [7:0] ctrl(bit rd, logic [2:0] p);
    return {4'b1011, p, rd};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_c();
    ev_start_i = 1'b1; @(negedge clk); ev_start_i = 1'b0;
  endtask
  task automatic stop_c();
    ev_stop_i = 1'b1; @(negedge clk); ev_stop_i = 1'b0;
  endtask
  task automatic adv();
    rd_adv_i = 1'b1; @(negedge clk); rd_adv_i = 1'b0;
  endtask
  task automatic send(logic [7:0] b, bit exp_ack, string tag);
    ev_byte_i = 1'b1; byte_i = b; @(negedge clk); ev_byte_i = 1'b0;
    chk({tag, " R9 vld"}, ack_vld_o, 1'b1);
    chk(tag, ack_o, exp_ack);
  endtask

  task automatic addr_phase(bit a10, logic [4:0] ofs);
    logic [7:0] hi, lo;
    hi = 8'($urandom);
    hi[2] = a10;
    lo = {3'($urandom), ofs};
    send(ctrl(1'b0, pins_i), 1'b1, "R1 ctrl");
    send(hi, 1'b1, "R2 addr hi");
    send(lo, 1'b1, "R2 addr lo");
  endtask

  task automatic page_write(logic [4:0] ofs, int len, bit commit);
    logic [7:0] d;
    logic [4:0] p;
    logic [7:0] tmp [32];
    tmp = ref_pg;
    p = ofs;
    start_c();
    addr_phase(1'b0, ofs);
    for (int i = 0; i < len; i++) begin
      d = 8'($urandom);
      send(d, exp_data_ack(ref_lock), "R3 data");
      if (!ref_lock) begin tmp[p] = d; p = p + 1'b1; end
    end
    if (commit) begin
      ref_pg = tmp;
    end else begin
      start_c();
    end
    stop_c();
  endtask

  task automatic page_read(logic [4:0] ofs, int len);
    logic [4:0] p;
    p = ofs;
    start_c();
    addr_phase(1'b0, ofs);
    start_c();
    send(ctrl(1'b1, pins_i), 1'b1, "R7 rd ctrl");
    chk("R7 rd_mode", rd_mode_o, 1'b1);
    for (int i = 0; i < len; i++) begin
      chk("R7 rd data", rd_data_o, ref_pg[p]);
      adv();
      p = p + 1'b1;
    end
    stop_c();
  endtask

  task automatic lock_cmd(logic [7:0] d);
    start_c();
    addr_phase(1'b1, 5'($urandom));
    send(d, exp_data_ack(ref_lock), "R5 lock data");
    send(8'hff, 1'b0, "R5 extra byte");
    stop_c();
    if (!ref_lock && d[1]) ref_lock = 1'b1;
    chk("R5 locked", locked_o, ref_lock);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) ref_pg[i] = 8'h00;
    ref_lock = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4177));
    @(negedge clk);
    do_reset();
    // R8 reset state
    chk("R8 locked after reset", locked_o, 1'b0);
    chk("R8 rd_data after reset", rd_data_o, 8'h00);
    chk("R8 idle vld", ack_vld_o, 1'b0);
    chk("R8 idle rd_mode", rd_mode_o, 1'b0);

    // R1 foreign type code and wrong pins
    start_c();
    send(8'b1010_101_0, 1'b0, "R1 main type refused");
    send(8'h00, 1'b0, "R1 ignored follower");
    stop_c();
    start_c();
    send(ctrl(1'b0, 3'b010), 1'b0, "R1 wrong pins refused");
    send(8'h00, 1'b0, "R1 ignored addr");
    send(8'h00, 1'b0, "R1 ignored addr2");
    send(8'h5a, 1'b0, "R1 ignored data");
    stop_c();
    page_read(5'd0, 4);

    // R3 wrap and overwrite
    page_write(5'd28, 6, 1'b1);
    page_read(5'd26, 10);
    page_write(5'd3, 40, 1'b1);
    page_read(5'd0, 32);

    // R4 / R6 probe on unlocked page, aborted
    page_write(5'd9, 1, 1'b0);
    page_read(5'd9, 2);

    // R7 read wrap and current-address read
    page_read(5'd30, 4);
    start_c();
    send(ctrl(1'b1, pins_i), 1'b1, "R7 current read ctrl");
    chk("R7 current read data", rd_data_o, ref_pg[5'd2]);
    stop_c();

    // random mix
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 2) == 0)
        page_read(5'($urandom), $urandom_range(1, 32));
      else
        page_write(5'($urandom), $urandom_range(1, 36), $urandom_range(0, 3) != 0);
    end
    page_read(5'd0, 32);

    // R5 lock with bit1 clear leaves unlocked
    lock_cmd(8'b1111_1101);
    // R4 lock request aborted by start
    start_c();
    addr_phase(1'b1, 5'd0);
    send(8'h02, 1'b1, "R4 lock data before abort");
    start_c();
    stop_c();
    chk("R4 lock aborted", locked_o, 1'b0);
    // R5 real lock
    lock_cmd(8'h02);
    // R6 locked: writes refused, contents frozen, probe refused
    page_write(5'd0, 5, 1'b1);
    page_write(5'd17, 1, 1'b0);
    lock_cmd(8'hff);
    page_read(5'd0, 32);

    // R8 reset clears, preload sets
    do_reset();
    chk("R8 unlocked after reset", locked_o, 1'b0);
    page_read(5'd0, 3);
    lock_preload_i = 1'b1; @(negedge clk); lock_preload_i = 1'b0;
    ref_lock = 1'b1;
    @(negedge clk);
    chk("R8 preload locks", locked_o, 1'b1);
    page_write(5'd4, 3, 1'b1);
    page_read(5'd4, 3);

    done = 1'b1;
    finish_run();
  end
endmodule